// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out store for 36-bit words that connects a producer running on one clock with a consumer running on another, unrelated clock. The producer pushes a word with `wr_en` whenever `in_ready` is high. The consumer takes a word with `rd_en` whenever `not_empty` is high, and the word appears in the registered `rd_data` output. The depth is a power-of-two parameter and defaults to 1024.

Two threshold flags warn of fill levels before the hard limits. `almost_empty_n` lives in the read domain and compares the stored count against an offset X. `almost_full_n` lives in the write domain and compares the count against DEPTH minus an offset Y. Both offsets take preset values at reset. The producer can overwrite either of them through a small parallel programming port on the write clock.

Each pointer crosses to the other domain as Gray code through two flip-flops. A flag that depends on an event at the opposite port therefore clears on the second rising edge of its own clock after that event. A word that has been moved into the output register no longer counts as stored.

Top module: `fifo_dc_flags`

## Requirements
- R1: Words leave `rd_data` in the order they were accepted. `rd_data` takes the next word at the rclk edge where `rd_en` and `not_empty` are both high, and it holds its value at all other times.
- R2: `in_ready` is low exactly when DEPTH words are stored. A write attempted while `in_ready` is low is discarded and does not move the write pointer.
- R3: After a read that frees a location in a full FIFO, `in_ready` stays low after the first wclk rising edge and is high after the second wclk rising edge.
- R4: Once the FIFO is idle, `almost_empty_n` is low when the count is X or less and high when the count is X+1 or more.
- R5: After the write that raises the count from X to X+1, `almost_empty_n` is still low after the first rclk rising edge and is high after the second rclk rising edge.
- R6: Once the FIFO is idle, `almost_full_n` is low when the count is DEPTH-Y or more and high when the count is DEPTH-Y-1 or less.
- R7: After the read that lowers the count from DEPTH-Y to DEPTH-Y-1, `almost_full_n` is still low after the first wclk rising edge and is high after the second wclk rising edge.
- R8: While `rst` is high, and right after it is released, `in_ready` is 1, `almost_full_n` is 1, `almost_empty_n` is 0, `not_empty` is 0 and `rd_data` is 0. The offsets X and Y are set to PRESET_X and PRESET_Y (both 8 by default).
- R9: At a wclk edge where `prog_en` is high, `prog_val` is loaded into X when `prog_sel` is 0 and into Y when `prog_sel` is 1.
- R10: A read attempted while `not_empty` is low is discarded. It leaves `rd_data` and the read pointer unchanged.
- R11: The word that a read moves into `rd_data` stops counting at that same rclk edge. When the last stored word is read, `not_empty` falls at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst | input | 1 | Active-high reset, sampled synchronously by each domain |
| wr_en | input | 1 | Push request |
| wr_data | input | 36 | Word to push |
| prog_en | input | 1 | Load one offset from `prog_val` |
| prog_sel | input | 1 | 0 selects X (almost-empty), 1 selects Y (almost-full) |
| prog_val | input | log2(DEPTH) | New offset value |
| in_ready | output | 1 | High while a free location exists |
| almost_full_n | output | 1 | Low when the count is at least DEPTH-Y |
| rd_en | input | 1 | Pop request |
| rd_data | output | 36 | Registered output word |
| not_empty | output | 1 | High while at least one word is stored |
| almost_empty_n | output | 1 | Low when the count is X or less |

## Verification
A push and a pop can land in the same interval, each on its own clock. Then one domain moves its local pointer while the other domain's synchronized view of it is still stale. A random phase with a fixed seed drives both ports concurrently, often across the full and empty boundaries. Every popped word is compared with a bench-side queue, and all flags are compared with bench-computed thresholds once both clocks have settled. Directed cases then count the edges between an event at one port and the release of the flag at the other port. The wclk and rclk edges never coincide, so the first and second release edges are unambiguous.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    localparam int WORD_W = 36;

    typedef enum logic {
        OFS_EMPTY = 1'b0,
        OFS_FULL  = 1'b1
    } ofs_sel_e;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fifo_sync2.sv
module fifo_sync2 #(
    parameter int W       = 1,
    parameter int RST_VAL = 0
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= W'(RST_VAL);
            q      <= W'(RST_VAL);
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
    parameter int W     = 36,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
)(
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          rst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    // output register: a word placed here has left the counted contents
    always_ff @(posedge rclk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
    import fifo_pkg::*;
#(
    parameter int DEPTH    = 1024,
    parameter int PRESET_X = 8,
    parameter int PRESET_Y = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int PW      = AW + 1
)(
    input  logic          wclk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          prog_en,
    input  logic          prog_sel,
    input  logic [AW-1:0] prog_val,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-1:0] wptr_bin,
    output logic [PW-1:0] wgray,
    output logic          wr_go,
    output logic          in_ready,
    output logic          almost_full_n,
    output logic [AW-1:0] ofs_x
);
    logic [PW-1:0] rbin;
    logic [PW-1:0] used;
    logic [PW-1:0] wnext;
    logic [AW-1:0] ofs_y;

    assign rbin          = PW'(gray2bin(32'(rgray_s)));
    assign used          = wptr_bin - rbin;
    assign in_ready      = (used != PW'(DEPTH));
    assign wr_go         = wr_en && in_ready;
    assign almost_full_n = (used < (PW'(DEPTH) - PW'(ofs_y)));
    assign wnext         = wptr_bin + PW'(1);

    always_ff @(posedge wclk) begin
        if (rst) begin
            wptr_bin <= '0;
            wgray    <= '0;
        end else if (wr_go) begin
            wptr_bin <= wnext;
            wgray    <= PW'(bin2gray(32'(wnext)));
        end
    end

    always_ff @(posedge wclk) begin
        if (rst) begin
            ofs_x <= AW'(PRESET_X);
            ofs_y <= AW'(PRESET_Y);
        end else if (prog_en) begin
            if (ofs_sel_e'(prog_sel) == OFS_FULL) ofs_y <= prog_val;
            else                                   ofs_x <= prog_val;
        end
    end
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
    import fifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
)(
    input  logic          rclk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_s,
    input  logic [AW-1:0] ofs_x_s,
    output logic [PW-1:0] rptr_bin,
    output logic [PW-1:0] rgray,
    output logic          rd_go,
    output logic          not_empty,
    output logic          almost_empty_n
);
    logic [PW-1:0] wbin;
    logic [PW-1:0] used;
    logic [PW-1:0] rnext;

    assign wbin           = PW'(gray2bin(32'(wgray_s)));
    assign used           = wbin - rptr_bin;
    assign not_empty      = (used != '0);
    assign rd_go          = rd_en && not_empty;
    assign almost_empty_n = (used > PW'(ofs_x_s));
    assign rnext          = rptr_bin + PW'(1);

    always_ff @(posedge rclk) begin
        if (rst) begin
            rptr_bin <= '0;
            rgray    <= '0;
        end else if (rd_go) begin
            rptr_bin <= rnext;
            rgray    <= PW'(bin2gray(32'(rnext)));
        end
    end
endmodule

// File: rtl/fifo_dc_flags.sv
module fifo_dc_flags
    import fifo_pkg::*;
#(
    parameter int DEPTH    = 1024,
    parameter int PRESET_X = 8,
    parameter int PRESET_Y = 8
)(
    input  logic                       wclk,
    input  logic                       rclk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       prog_en,
    input  logic                       prog_sel,
    input  logic [$clog2(DEPTH)-1:0]   prog_val,
    output logic                       in_ready,
    output logic                       almost_full_n,
    input  logic                       rd_en,
    output logic [WORD_W-1:0]          rd_data,
    output logic                       not_empty,
    output logic                       almost_empty_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wptr_bin, wgray, wgray_s;
    logic [PW-1:0] rptr_bin, rgray, rgray_s;
    logic [AW-1:0] ofs_x, ofs_x_s;
    logic          wr_go, rd_go;

    fifo_wr_ctl #(.DEPTH(DEPTH), .PRESET_X(PRESET_X), .PRESET_Y(PRESET_Y)) u_wr (
        .wclk(wclk), .rst(rst), .wr_en(wr_en),
        .prog_en(prog_en), .prog_sel(prog_sel), .prog_val(prog_val),
        .rgray_s(rgray_s), .wptr_bin(wptr_bin), .wgray(wgray), .wr_go(wr_go),
        .in_ready(in_ready), .almost_full_n(almost_full_n), .ofs_x(ofs_x)
    );

    fifo_rd_ctl #(.DEPTH(DEPTH)) u_rd (
        .rclk(rclk), .rst(rst), .rd_en(rd_en),
        .wgray_s(wgray_s), .ofs_x_s(ofs_x_s),
        .rptr_bin(rptr_bin), .rgray(rgray), .rd_go(rd_go),
        .not_empty(not_empty), .almost_empty_n(almost_empty_n)
    );

    fifo_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_s));
    fifo_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_s));
    fifo_sync2 #(.W(AW), .RST_VAL(PRESET_X)) u_xofs (
        .clk(rclk), .rst(rst), .d(ofs_x), .q(ofs_x_s)
    );

    fifo_mem #(.W(WORD_W), .DEPTH(DEPTH)) u_mem (
        .wclk(wclk), .we(wr_go), .waddr(wptr_bin[AW-1:0]), .wdata(wr_data),
        .rclk(rclk), .rst(rst), .re(rd_go), .raddr(rptr_bin[AW-1:0]), .rdata(rd_data)
    );
endmodule

// File: rtl/fifo_dc_chk.sv
module fifo_dc_chk #(
    parameter int PW = 11,
    parameter int W  = 36
)(
    input logic          wclk,
    input logic          rclk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          in_ready,
    input logic          not_empty,
    input logic          almost_full_n,
    input logic          almost_empty_n,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr,
    input logic [W-1:0]  rd_data
);
    // R1: an accepted push advances the write pointer by exactly one
    a_r1_wptr_step: assert property (@(posedge wclk) disable iff (rst)
        (wr_en && in_ready) |=> (wptr == $past(wptr) + PW'(1)));

    // R2: a push while full leaves the write pointer alone
    a_r2_no_overflow: assert property (@(posedge wclk) disable iff (rst)
        (wr_en && !in_ready) |=> $stable(wptr));

    // R10: a pop while empty moves neither the read pointer nor the output
    a_r10_no_underflow: assert property (@(posedge rclk) disable iff (rst)
        (rd_en && !not_empty) |=> ($stable(rptr) && $stable(rd_data)));

    // R4: an empty FIFO is always below the almost-empty threshold
    a_r4_empty_low: assert property (@(posedge rclk) disable iff (rst)
        !not_empty |-> !almost_empty_n);

    // R6: a full FIFO is always at or above the almost-full threshold
    a_r6_full_low: assert property (@(posedge wclk) disable iff (rst)
        !in_ready |-> !almost_full_n);
endmodule

bind fifo_dc_flags fifo_dc_chk #(.PW($clog2(DEPTH) + 1), .W(fifo_pkg::WORD_W)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .in_ready(in_ready), .not_empty(not_empty),
    .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n),
    .wptr(wptr_bin), .rptr(rptr_bin), .rd_data(rd_data)
);

// File: tb/sim_fifo_dc_flags.sv
`timescale 1ns/1ps
module sim_fifo_dc_flags;
    localparam int DEPTH        = 16;
    localparam int AW           = 4;
    localparam int PRE          = 8;
    localparam int WCLK_PERIOD  = 10;
    localparam int RCLK_PERIOD  = 12;

    logic          wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [35:0]   wr_data = '0;
    logic          prog_en = 1'b0, prog_sel = 1'b0;
    logic [AW-1:0] prog_val = '0;
    logic          in_ready, almost_full_n, not_empty, almost_empty_n;
    logic [35:0]   rd_data;

    logic [35:0] mq[$];
    logic [35:0] last_rd = '0;
    int x_ofs = PRE, y_ofs = PRE;
    int checks = 0, errors = 0;

    always #(WCLK_PERIOD/2) wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    fifo_dc_flags #(.DEPTH(DEPTH), .PRESET_X(PRE), .PRESET_Y(PRE)) u0 (
        .wclk(wclk), .rclk(rclk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data),
        .prog_en(prog_en), .prog_sel(prog_sel), .prog_val(prog_val),
        .in_ready(in_ready), .almost_full_n(almost_full_n),
        .rd_en(rd_en), .rd_data(rd_data),
        .not_empty(not_empty), .almost_empty_n(almost_empty_n)
    );

    function automatic logic exp_ae(int cnt); return cnt > x_ofs; endfunction
    function automatic logic exp_af(int cnt); return cnt <= DEPTH - y_ofs - 1; endfunction
    function automatic logic exp_rdy(int cnt); return cnt < DEPTH; endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic [35:0] d);
        logic acc;
        @(negedge wclk);
        wr_en = 1'b1; wr_data = d; acc = in_ready;
        @(posedge wclk);
        wr_en <= 1'b0;
        if (acc) mq.push_back(d);
    endtask

    task automatic pop();
        logic acc;
        logic [35:0] e;
        @(negedge rclk);
        rd_en = 1'b1; acc = not_empty;
        @(posedge rclk);
        rd_en <= 1'b0;
        if (acc) begin
            e = mq.pop_front();
            last_rd = e;
            #1 chk("R1 data order", 64'(rd_data), 64'(e));
        end else begin
            #1 chk("R10 empty read holds rd_data", 64'(rd_data), 64'(last_rd));
        end
    endtask

    task automatic prog(input logic sel, input logic [AW-1:0] v);
        @(negedge wclk);
        prog_en = 1'b1; prog_sel = sel; prog_val = v;
        @(posedge wclk);
        prog_en <= 1'b0;
        if (sel) y_ofs = int'(v); else x_ofs = int'(v);
    endtask

    task automatic settle(input string tag);
        int c;
        repeat (4) @(posedge wclk);
        repeat (4) @(posedge rclk);
        #1;
        c = mq.size();
        chk({tag, " R2 in_ready"}, 64'(in_ready), 64'(exp_rdy(c)));
        chk({tag, " R4 almost_empty_n"}, 64'(almost_empty_n), 64'(exp_ae(c)));
        chk({tag, " R6 almost_full_n"}, 64'(almost_full_n), 64'(exp_af(c)));
        chk({tag, " R11 not_empty"}, 64'(not_empty), 64'(c > 0));
    endtask

    function automatic logic [35:0] rnd36();
        return 36'({$urandom(), $urandom()});
    endfunction

    initial begin
        #(WCLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [35:0] e;
        void'($urandom(32'd20240611));
        repeat (5) @(posedge wclk);
        repeat (5) @(posedge rclk);
        #1;
        // R8: reset state
        chk("R8 in_ready", 64'(in_ready), 64'd1);
        chk("R8 almost_full_n", 64'(almost_full_n), 64'd1);
        chk("R8 almost_empty_n", 64'(almost_empty_n), 64'd0);
        chk("R8 not_empty", 64'(not_empty), 64'd0);
        chk("R8 rd_data", 64'(rd_data), 64'd0);
        @(negedge wclk) rst = 1'b0;
        settle("after reset R8");

        // R4 at count X with the preset offset
        for (int i = 0; i < PRE; i++) push(36'h100 + 36'(i));
        settle("count X");

        // R5: push X+1 and count rclk edges
        @(negedge wclk);
        wr_en = 1'b1; wr_data = 36'hABC;
        @(posedge wclk);
        wr_en <= 1'b0;
        mq.push_back(36'hABC);
        @(posedge rclk); #1 chk("R5 first rclk edge", 64'(almost_empty_n), 64'd0);
        @(posedge rclk); #1 chk("R5 second rclk edge", 64'(almost_empty_n), 64'd1);

        // fill up, then R2 overflow attempt
        while (mq.size() < DEPTH) push(rnd36());
        settle("full");
        push(36'hDEAD_BEEF);
        settle("after overflow attempt R2");

        // R3: one read from full, count wclk edges
        @(negedge rclk);
        rd_en = 1'b1;
        @(posedge rclk);
        rd_en <= 1'b0;
        e = mq.pop_front();
        last_rd = e;
        @(posedge wclk); #1 chk("R3 first wclk edge", 64'(in_ready), 64'd0);
        @(posedge wclk); #1 chk("R3 second wclk edge", 64'(in_ready), 64'd1);
        chk("R1 data after full read", 64'(rd_data), 64'(e));

        // R7: down to DEPTH-Y, then one more read
        while (mq.size() > DEPTH - PRE) pop();
        settle("count DEPTH-Y");
        @(negedge rclk);
        rd_en = 1'b1;
        @(posedge rclk);
        rd_en <= 1'b0;
        e = mq.pop_front();
        last_rd = e;
        @(posedge wclk); #1 chk("R7 first wclk edge", 64'(almost_full_n), 64'd0);
        @(posedge wclk); #1 chk("R7 second wclk edge", 64'(almost_full_n), 64'd1);

        // drain; R11 not_empty falls at the edge taking the last word
        while (mq.size() > 0) pop();
        chk("R11 not_empty at last read", 64'(not_empty), 64'd0);
        pop();      // R10 read while empty
        settle("empty after R10");

        // R9: programmed offsets
        prog(1'b0, 4'd3);
        prog(1'b1, 4'd2);
        for (int i = 0; i < 3; i++) push(rnd36());
        settle("R9 X=3 count 3");
        push(rnd36());
        settle("R9 X=3 count 4");
        while (mq.size() < DEPTH - 3) push(rnd36());
        settle("R9 Y=2 count 13");
        push(rnd36());
        settle("R9 Y=2 count 14");
        while (mq.size() > 0) pop();
        settle("R9 drained");

        // concurrent random traffic
        fork
            begin
                for (int i = 0; i < 400; i++) begin
                    if ($urandom_range(0, 2) != 0) push(rnd36());
                    else @(posedge wclk);
                end
            end
            begin
                for (int i = 0; i < 400; i++) begin
                    if ($urandom_range(0, 2) != 0) pop();
                    else @(posedge rclk);
                end
            end
        join
        settle("random R1");
        while (mq.size() > 0) pop();
        settle("random drained");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule